// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the horizontal and vertical position counters of a raster display, together with a display-enable window, horizontal and vertical sync pulses and a per-line early fetch strobe. It runs from the pixel clock. All of its geometry comes from a small register file that is loaded through a synchronous write port. Every boundary value is written as a last position, that is the count minus one, so the counters compare directly against what software wrote.

Timing values are written into a staging set. They reach the live set that drives the counters and comparators either while the generator is disabled or at the boundary after the last pixel of the last line. Software can therefore reprogram a running display without tearing a frame. The usual sequence is to clear the control register, write the geometry and then set enable and refresh again. The refresh bit gates the display window and the fetch strobe only, so syncs keep running while the picture is suppressed.

Top module: `raster_timing_gen`

## Requirements
- R1: A write with `wr_en` high is captured at the rising edge. Address map: 0 control (bit 0 enable, bit 1 refresh), 1 horizontal last position, 2 horizontal display last, 3 hsync start, 4 hsync end, 5 vertical last line, 6 vertical display last, 7 vsync start, 8 vsync end, 9 fetch strobe position.
- R2: While enable reads low, `disp_en`, `hsync`, `vsync` and `fetch_stb` are low in that same cycle, and `h_pos`/`v_pos` are zero from the following edge on.
- R3: In the first cycle after the write that sets enable, `h_pos` is 0. It then rises by one each clock and returns to 0 after the cycle in which it equals the horizontal last position.
- R4: `v_pos` rises by one in the cycle after each horizontal wrap, and returns to 0 after the horizontal wrap on the vertical last line.
- R5: `disp_en` is high when enable and refresh are set, `h_pos` is at or below the horizontal display last, and `v_pos` is at or below the vertical display last.
- R6: `hsync` is high while enabled and hsync start < `h_pos` <= hsync end.
- R7: `vsync` is high while enabled and vsync start < `v_pos` <= vsync end.
- R8: `fetch_stb` is high for the single cycle of each line in which `h_pos` equals the fetch position, including position 0, while enable and refresh are set.
- R9: Timing registers written while enabled take effect only from the cycle after the last pixel of the last line. Values written while disabled are in force from the first enabled cycle.
- R10: With enable set and refresh clear, `disp_en` and `fetch_stb` stay low while the counters, `hsync` and `vsync` keep running.
- R11: Address 10 (alternate hsync end, written by software with the same value as address 4) and addresses 11 to 15 accept writes that change no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register address |
| wr_data | input | CNT_W | Register write data |
| h_pos | output | CNT_W | Horizontal pixel counter |
| v_pos | output | CNT_W | Vertical line counter |
| disp_en | output | 1 | Active picture window |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| fetch_stb | output | 1 | Per-line early fetch strobe |

## Verification
The counters and the control bits are flops. Every output is decoded from them without further registers, so each result belongs to the cycle that follows the edge that moved the counters. A control write changes the gating in the cycle right after its own edge, and the counters reach zero one edge later. Geometry writes made while the generator runs show up only after the frame-end edge. The bench updates its reference model on the rising edge from the inputs it drove on the previous falling edge. It compares the model with every output on the falling edge, and it also counts events over whole frames at known frame starts.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
  localparam int POS_W  = 16;
  localparam int SLOT_N = 9;

  // register address map
  localparam int A_CTRL    = 0;
  localparam int A_H_LAST  = 1;
  localparam int A_H_VIS   = 2;
  localparam int A_HS_LO   = 3;
  localparam int A_HS_HI   = 4;
  localparam int A_V_LAST  = 5;
  localparam int A_V_VIS   = 6;
  localparam int A_VS_LO   = 7;
  localparam int A_VS_HI   = 8;
  localparam int A_FETCH   = 9;
  localparam int A_HS_ALT  = 10;

  // position strictly past lo and not past hi (last-position encoding)
  function automatic logic in_span(input logic [POS_W-1:0] pos,
                                   input logic [POS_W-1:0] lo,
                                   input logic [POS_W-1:0] hi);
    return (pos > lo) && (pos <= hi);
  endfunction

  function automatic logic not_beyond(input logic [POS_W-1:0] pos,
                                      input logic [POS_W-1:0] lim);
    return pos <= lim;
  endfunction
endpackage

// File: rtl/rtg_regs.sv
module rtg_regs import rtg_pkg::*; #(
  parameter int CNT_W  = 12,
  parameter int ADDR_W = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             wr_addr,
  input  logic [CNT_W-1:0]              wr_data,
  input  logic                          frame_end,
  output logic                          run,
  output logic                          refresh,
  output logic [SLOT_N:1][CNT_W-1:0]    live
);
  logic [SLOT_N:1][CNT_W-1:0] staged;
  logic                       load;

  // live set follows the staged set while idle or at the frame boundary
  assign load = !run || frame_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run     <= 1'b0;
      refresh <= 1'b0;
    end else if (wr_en && (wr_addr == ADDR_W'(A_CTRL))) begin
      run     <= wr_data[0];
      refresh <= wr_data[1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      staged <= '0;
      live   <= '0;
    end else begin
      if (load) live <= staged;
      for (int s = 1; s <= SLOT_N; s++) begin
        if (wr_en && (wr_addr == ADDR_W'(s))) staged[s] <= wr_data;
      end
    end
  end
endmodule

// File: rtl/rtg_axis.sv
module rtg_axis #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             step,
  input  logic [CNT_W-1:0] last,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  assign wrap = run && step && (cnt == last);

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt <= '0;
    else if (!run)  cnt <= '0;
    else if (step)  cnt <= wrap ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/rtg_decode.sv
module rtg_decode import rtg_pkg::*; #(
  parameter int CNT_W = 12
) (
  input  logic             run,
  input  logic             refresh,
  input  logic [CNT_W-1:0] h,
  input  logic [CNT_W-1:0] v,
  input  logic [CNT_W-1:0] h_vis,
  input  logic [CNT_W-1:0] hs_lo,
  input  logic [CNT_W-1:0] hs_hi,
  input  logic [CNT_W-1:0] v_vis,
  input  logic [CNT_W-1:0] vs_lo,
  input  logic [CNT_W-1:0] vs_hi,
  input  logic [CNT_W-1:0] fetch_at,
  output logic             disp_en,
  output logic             hsync,
  output logic             vsync,
  output logic             fetch_stb
);
  logic in_window, h_sync_zone, v_sync_zone, fetch_hit;

  assign in_window   = not_beyond(POS_W'(h), POS_W'(h_vis)) &&
                       not_beyond(POS_W'(v), POS_W'(v_vis));
  assign h_sync_zone = in_span(POS_W'(h), POS_W'(hs_lo), POS_W'(hs_hi));
  assign v_sync_zone = in_span(POS_W'(v), POS_W'(vs_lo), POS_W'(vs_hi));
  assign fetch_hit   = (h == fetch_at);

  assign disp_en   = run && refresh && in_window;
  assign fetch_stb = run && refresh && fetch_hit;
  assign hsync     = run && h_sync_zone;
  assign vsync     = run && v_sync_zone;
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen import rtg_pkg::*; #(
  parameter int CNT_W  = 12,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  output logic [CNT_W-1:0]  h_pos,
  output logic [CNT_W-1:0]  v_pos,
  output logic              disp_en,
  output logic              hsync,
  output logic              vsync,
  output logic              fetch_stb
);
  logic                       run;
  logic                       refresh;
  logic [SLOT_N:1][CNT_W-1:0] live;
  logic                       h_wrap;
  logic                       frame_end;

  rtg_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .frame_end(frame_end), .run(run),
    .refresh(refresh), .live(live)
  );

  rtg_axis #(.CNT_W(CNT_W)) u_h_axis (
    .clk(clk), .rst_n(rst_n), .run(run), .step(1'b1),
    .last(live[A_H_LAST]), .cnt(h_pos), .wrap(h_wrap)
  );

  rtg_axis #(.CNT_W(CNT_W)) u_v_axis (
    .clk(clk), .rst_n(rst_n), .run(run), .step(h_wrap),
    .last(live[A_V_LAST]), .cnt(v_pos), .wrap(frame_end)
  );

  rtg_decode #(.CNT_W(CNT_W)) u_decode (
    .run(run), .refresh(refresh), .h(h_pos), .v(v_pos),
    .h_vis(live[A_H_VIS]), .hs_lo(live[A_HS_LO]), .hs_hi(live[A_HS_HI]),
    .v_vis(live[A_V_VIS]), .vs_lo(live[A_VS_LO]), .vs_hi(live[A_VS_HI]),
    .fetch_at(live[A_FETCH]),
    .disp_en(disp_en), .hsync(hsync), .vsync(vsync), .fetch_stb(fetch_stb)
  );
endmodule

// File: rtl/rtg_chk.sv
module rtg_chk #(
  parameter int CNT_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             refresh,
  input logic             h_wrap,
  input logic [CNT_W-1:0] h_pos,
  input logic [CNT_W-1:0] v_pos,
  input logic             disp_en,
  input logic             hsync,
  input logic             vsync,
  input logic             fetch_stb
);
  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (!disp_en && !hsync && !vsync && !fetch_stb));

  // R2
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (h_pos == '0 && v_pos == '0));

  // R3
  h_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    h_wrap |=> (h_pos == '0));

  // R3
  h_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !h_wrap) |=> (!run || h_pos == $past(h_pos) + 1'b1));

  // R4
  v_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !h_wrap) |=> (!run || $stable(v_pos)));

  // R10
  refresh_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !refresh |-> (!disp_en && !fetch_stb));
endmodule

bind raster_timing_gen rtg_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .refresh(refresh), .h_wrap(h_wrap),
  .h_pos(h_pos), .v_pos(v_pos), .disp_en(disp_en), .hsync(hsync),
  .vsync(vsync), .fetch_stb(fetch_stb)
);

// File: tb/raster_timing_gen_tb_top.sv
`timescale 1ns/1ps
module raster_timing_gen_tb_top;
  localparam int CW = 12;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [CW-1:0] wr_data = '0;
  logic [CW-1:0] h_pos, v_pos;
  logic          disp_en, hsync, vsync, fetch_stb;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit compare_on = 1'b0;

  // reference model state
  int mstage [1:9];
  int mlive  [1:9];
  bit mrun, mref;
  int mh, mv;

  always #2.5 clk = ~clk;

  raster_timing_gen #(.CNT_W(CW), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .h_pos(h_pos), .v_pos(v_pos), .disp_en(disp_en),
    .hsync(hsync), .vsync(vsync), .fetch_stb(fetch_stb)
  );

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s got=%0d exp=%0d at %0t", tag, got, exp, $time);
    end
  endtask

  // behavioural reference, advanced on every rising edge
  always @(posedge clk) begin
    bit hw, fe;
    int nh, nv;
    if (!rst_n) begin
      mrun = 0; mref = 0; mh = 0; mv = 0;
      for (int s = 1; s <= 9; s++) begin mstage[s] = 0; mlive[s] = 0; end
    end else begin
      hw = mrun && (mh == mlive[1]);
      fe = hw && (mv == mlive[5]);
      if (!mrun) begin nh = 0; nv = 0; end
      else if (hw) begin nh = 0; nv = fe ? 0 : mv + 1; end
      else begin nh = mh + 1; nv = mv; end
      if (!mrun || fe)
        for (int s = 1; s <= 9; s++) mlive[s] = mstage[s];
      if (wr_en) begin
        if (wr_addr == 0) begin mrun = wr_data[0]; mref = wr_data[1]; end
        else if (wr_addr <= 9) mstage[int'(wr_addr)] = int'(wr_data);
      end
      mh = nh; mv = nv;
    end
  end

  always @(negedge clk) begin
    if (rst_n && compare_on) begin
      chk("R3 h_pos", int'(h_pos), mh);
      chk("R4 v_pos", int'(v_pos), mv);
      chk("R5 disp_en", int'(disp_en),
          int'(mrun && mref && mh <= mlive[2] && mv <= mlive[6]));
      chk("R6 hsync", int'(hsync), int'(mrun && mh > mlive[3] && mh <= mlive[4]));
      chk("R7 vsync", int'(vsync), int'(mrun && mv > mlive[7] && mv <= mlive[8]));
      chk("R8 fetch_stb", int'(fetch_stb), int'(mrun && mref && mh == mlive[9]));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = CW'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic program_geom(input int hl, hv, hsl, hsh, vl, vv, vsl, vsh, fp);
    wr(1, hl); wr(2, hv); wr(3, hsl); wr(4, hsh);
    wr(5, vl); wr(6, vv); wr(7, vsl); wr(8, vsh); wr(9, fp);
  endtask

  task automatic frame_counts(input int n, output int nde, output int nhs,
                              output int nvs, output int npf,
                              output int maxh, output int maxv);
    nde = 0; nhs = 0; nvs = 0; npf = 0; maxh = 0; maxv = 0;
    do @(negedge clk); while (!(h_pos == 0 && v_pos == 0));
    for (int i = 0; i < n; i++) begin
      if (i > 0) @(negedge clk);
      nde += int'(disp_en); nhs += int'(hsync);
      nvs += int'(vsync);   npf += int'(fetch_stb);
      if (int'(h_pos) > maxh) maxh = int'(h_pos);
      if (int'(v_pos) > maxv) maxv = int'(v_pos);
    end
  endtask

  initial begin
    int nde, nhs, nvs, npf, mxh, mxv;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    compare_on = 1'b1;
    @(negedge clk);
    // R2 reset state
    chk("R2 reset h_pos", int'(h_pos), 0);
    chk("R2 reset v_pos", int'(v_pos), 0);
    chk("R2 reset outputs", int'({disp_en, hsync, vsync, fetch_stb}), 0);

    // R1 geometry A, plus R11 writes that must not matter
    program_geom(19, 11, 13, 16, 9, 5, 6, 7, 15);
    wr(10, 14);
    wr(15, 1);
    wr(0, 3);
    chk("R3 first enabled h_pos", int'(h_pos), 0);
    chk("R3 first enabled v_pos", int'(v_pos), 0);
    @(negedge clk);
    chk("R3 second enabled h_pos", int'(h_pos), 1);

    frame_counts(200, nde, nhs, nvs, npf, mxh, mxv);
    chk("R5 frame disp_en count", nde, 72);
    chk("R6 R11 frame hsync count", nhs, 30);
    chk("R7 frame vsync count", nvs, 20);
    chk("R8 frame fetch count", npf, 10);
    chk("R3 max h_pos", mxh, 19);
    chk("R4 max v_pos", mxv, 9);

    // R9 mid-frame change of the horizontal display last
    do @(negedge clk); while (v_pos != 2);
    wr(2, 7);
    do @(negedge clk); while (!(v_pos == 3 && h_pos == 10));
    chk("R9 old display width kept in frame", int'(disp_en), 1);
    frame_counts(200, nde, nhs, nvs, npf, mxh, mxv);
    chk("R9 new display width next frame", nde, 48);

    // R10 refresh off, enable on
    wr(0, 1);
    frame_counts(200, nde, nhs, nvs, npf, mxh, mxv);
    chk("R10 disp_en suppressed", nde, 0);
    chk("R10 fetch suppressed", npf, 0);
    chk("R10 hsync continues", nhs, 30);
    chk("R10 vsync continues", nvs, 20);

    // R2 disable
    wr(0, 0);
    chk("R2 outputs low when disabled", int'({disp_en, hsync, vsync, fetch_stb}), 0);
    @(negedge clk);
    chk("R2 h_pos zero when disabled", int'(h_pos), 0);
    chk("R2 v_pos zero when disabled", int'(v_pos), 0);

    // R1 R9 geometry B written while idle, fetch at position 0
    program_geom(29, 23, 25, 27, 4, 2, 3, 4, 0);
    wr(0, 3);
    frame_counts(150, nde, nhs, nvs, npf, mxh, mxv);
    chk("R5 B disp_en count", nde, 72);
    chk("R6 B hsync count", nhs, 10);
    chk("R7 B vsync count", nvs, 30);
    chk("R8 B fetch at zero count", npf, 5);
    chk("R3 B max h_pos", mxh, 29);
    chk("R4 B max v_pos", mxv, 4);

    repeat (3) @(negedge clk);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule